// File: doc/BRIEF.md
# Dual-Mode Register Bank with Serial Test Chain

This block is a bank of `WIDTH` flip-flops sharing one clock. An elaboration-time parameter picks its personality: in data mode each enabled rising edge copies the `data` vector into the bank; in toggle mode each enabled edge inverts exactly those bits whose `data` bit is 1. Three asynchronous controls (clear, set to a constant, load from `data`) override the clock at once. Three synchronous counterparts (clear, set to a second constant, load) act on the next enabled edge. The two set constants are parameters. When either one is marked as not supplied, the matching set drives all ones. Load, in either form, exists only in toggle mode.

A clock enable gates every synchronous action. A test-enable input turns the bank into a shift chain: `testin` feeds bit 0, each bit moves one place up, and `testout` always shows the top bit. The power-on contents come from a parameter. An integrator who has no use for the enable ties it high.

Top module: `dt_scan_reg`

## Requirements
- R1: In data mode, with `enable`=1, `testenab`=0 and no synchronous control active, `q` equals the `data` present at the rising edge.
- R2: In toggle mode, under the same conditions, each bit `q[i]` inverts at the edge when `data[i]`=1 and holds when `data[i]`=0.
- R3: With `enable`=0 and no asynchronous control active, `q` does not change at a clock edge, whatever `sclr`, `sset`, `sload`, `testenab` or `data` carry.
- R4: `sclr`=1 with `enable`=1 and `testenab`=0 makes `q` all zeros after the edge, ahead of `sset`, `sload` and the mode operation.
- R5: `sset`=1 (with `enable`=1, `testenab`=0, `sclr`=0) loads `SVAL` at the edge if `HAS_SVAL`=1, otherwise all ones, ahead of `sload` and the mode operation.
- R6: In toggle mode, `sload`=1 (with `enable`=1, `testenab`=0, `sclr`=0, `sset`=0) copies `data` into `q` at the edge. In data mode, asserting `aload` or `sload` is an error that an assertion reports.
- R7: `aclr`=1 forces `q` to all zeros at once, without a clock edge, and overrides every other control.
- R8: `aset`=1 with `aclr`=0 forces `q` at once to `AVAL` if `HAS_AVAL`=1, otherwise all ones, and overrides `aload`.
- R9: In toggle mode, `aload`=1 with `aclr`=0 and `aset`=0 copies `data` into `q` at its rising edge, and again at every rising clock edge while it stays high, regardless of `enable`.
- R10: After every asynchronous control has been released, `q` keeps its value until the next enabled clock edge.
- R11: With `enable`=1 and `testenab`=1, each edge sets `q[i+1]` to the old `q[i]` and `q[0]` to `testin`. This takes priority over all other synchronous controls.
- R12: `testout` equals `q[WIDTH-1]` at all times.
- R13: Before the first clock edge and before any asynchronous control, `q` equals `INIT_VAL`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| enable | input | 1 | Gates every synchronous action |
| data | input | WIDTH | Load value (data mode) or toggle mask (toggle mode) |
| aclr | input | 1 | Asynchronous clear, active high |
| aset | input | 1 | Asynchronous set to the A constant, active high |
| aload | input | 1 | Asynchronous load of `data`, toggle mode only |
| sclr | input | 1 | Synchronous clear |
| sset | input | 1 | Synchronous set to the S constant |
| sload | input | 1 | Synchronous load of `data`, toggle mode only |
| testenab | input | 1 | Selects serial shift operation |
| testin | input | 1 | Serial input into bit 0 |
| q | output | WIDTH | Register contents |
| testout | output | 1 | Serial output, the top bit of `q` |

## Verification
Every synchronous result (load, toggle, clear, set, shift, hold) is due one edge after the controls that cause it. The bench drives those controls at a falling edge and samples `q` one nanosecond after the next rising edge, so each comparison covers exactly one register stage. Asynchronous results (clear, set, load) are due at once. They are sampled one nanosecond after the control changes, mid-cycle, with no clock edge in between. Release behaviour is checked one enabled-low edge later. `testout` is compared in every sample against the expected top bit.

// File: rtl/dt_reg_pkg.sv
package dt_reg_pkg;
    typedef enum logic {
        FF_D = 1'b0,
        FF_T = 1'b1
    } ff_kind_e;
endpackage

// File: rtl/dt_scan_shift.sv
module dt_scan_shift #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             ser_in,
    output logic [WIDTH-1:0] shifted
);
    generate
        if (WIDTH == 1) begin : g_single
            assign shifted = ser_in;
        end else begin : g_chain
            assign shifted = {cur[WIDTH-2:0], ser_in};
        end
    endgenerate
endmodule

// File: rtl/dt_sync_next.sv
module dt_sync_next
    import dt_reg_pkg::*;
#(
    parameter ff_kind_e         KIND  = FF_D,
    parameter int               WIDTH = 8,
    parameter logic [WIDTH-1:0] S_VAL = '1
) (
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] din,
    input  logic [WIDTH-1:0] shifted,
    input  logic             shift_sel,
    input  logic             clr_sel,
    input  logic             set_sel,
    input  logic             load_sel,
    output logic [WIDTH-1:0] nxt
);
    logic [WIDTH-1:0] mode_val;
    logic             load_ok;

    generate
        if (KIND == FF_T) begin : g_toggle
            assign mode_val = cur ^ din;
            assign load_ok  = load_sel;
        end else begin : g_data
            assign mode_val = din;
            assign load_ok  = 1'b0;
        end
    endgenerate

    always_comb begin
        if (shift_sel)      nxt = shifted;
        else if (clr_sel)   nxt = '0;
        else if (set_sel)   nxt = S_VAL;
        else if (load_ok)   nxt = din;
        else                nxt = mode_val;
    end
endmodule

// File: rtl/dt_scan_reg.sv
module dt_scan_reg
    import dt_reg_pkg::*;
#(
    parameter ff_kind_e         KIND     = FF_D,
    parameter int               WIDTH    = 8,
    parameter bit               HAS_AVAL = 1'b0,
    parameter logic [WIDTH-1:0] AVAL     = '0,
    parameter bit               HAS_SVAL = 1'b0,
    parameter logic [WIDTH-1:0] SVAL     = '0,
    parameter logic [WIDTH-1:0] INIT_VAL = '0
) (
    input  logic             clk,
    input  logic             enable,
    input  logic [WIDTH-1:0] data,
    input  logic             aclr,
    input  logic             aset,
    input  logic             aload,
    input  logic             sclr,
    input  logic             sset,
    input  logic             sload,
    input  logic             testenab,
    input  logic             testin,
    output logic [WIDTH-1:0] q,
    output logic             testout
);
    localparam logic [WIDTH-1:0] SET_A = HAS_AVAL ? AVAL : {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] SET_S = HAS_SVAL ? SVAL : {WIDTH{1'b1}};

    typedef struct packed {
        logic [WIDTH-1:0] val;
        logic             upd;
    } reg_next_t;

    logic [WIDTH-1:0] bank_q = INIT_VAL;
    logic [WIDTH-1:0] shift_vec;
    logic [WIDTH-1:0] sync_val;
    logic             aload_eff;
    reg_next_t        next_d;

    generate
        if (KIND == FF_T) begin : g_aload
            assign aload_eff = aload;
        end else begin : g_no_aload
            assign aload_eff = 1'b0;
        end
    endgenerate

    dt_scan_shift #(.WIDTH(WIDTH)) u_shift (
        .cur     (bank_q),
        .ser_in  (testin),
        .shifted (shift_vec)
    );

    dt_sync_next #(.KIND(KIND), .WIDTH(WIDTH), .S_VAL(SET_S)) u_next (
        .cur       (bank_q),
        .din       (data),
        .shifted   (shift_vec),
        .shift_sel (testenab),
        .clr_sel   (sclr),
        .set_sel   (sset),
        .load_sel  (sload),
        .nxt       (sync_val)
    );

    always_comb begin
        next_d.val = sync_val;
        next_d.upd = enable;
    end

    always_ff @(posedge clk or posedge aclr or posedge aset or posedge aload_eff) begin
        if (aclr)            bank_q <= '0;
        else if (aset)       bank_q <= SET_A;
        else if (aload_eff)  bank_q <= data;
        else if (next_d.upd) bank_q <= next_d.val;
    end

    assign q       = bank_q;
    assign testout = bank_q[WIDTH-1];

    // Asynchronous overrides as seen at a clock edge
    p_aclr_r7: assert property (@(posedge clk) aclr |-> (q == '0))
        else $error("aclr did not hold q at zero");
    p_aset_r8: assert property (@(posedge clk) disable iff (aclr) aset |-> (q == SET_A))
        else $error("aset did not hold q at its constant");

    // Synchronous behaviour one edge later
    p_hold_r3: assert property (@(posedge clk) disable iff (aclr)
        (!enable && !aset && !aload_eff) |=> (aset || aload_eff || q == $past(q)))
        else $error("q moved with enable low");
    p_sclr_r4: assert property (@(posedge clk) disable iff (aclr)
        (enable && !testenab && sclr && !aset && !aload_eff) |=> (aset || aload_eff || q == '0))
        else $error("sclr did not clear q");
    p_shift_r11: assert property (@(posedge clk) disable iff (aclr)
        (enable && testenab && !aset && !aload_eff) |=> (aset || aload_eff || q[0] == $past(testin)))
        else $error("shift did not take testin into bit 0");

    generate
        if (KIND == FF_D) begin : g_load_check
            p_dmode_load_r6: assert property (@(posedge clk) disable iff (aclr) !(aload || sload))
                else $error("load control used in data mode");
        end
    endgenerate
endmodule

// File: tb/tb_dt_scan_reg.sv
module tb_dt_scan_reg;
    import dt_reg_pkg::*;

    logic       clk = 1'b0;
    logic       enable = 1'b0, aclr = 1'b0, aset = 1'b0, aload = 1'b0;
    logic       sclr = 1'b0, sset = 1'b0, sload = 1'b0, testenab = 1'b0, testin = 1'b0;
    logic [7:0] data = 8'h00;
    logic       zero = 1'b0;

    logic [7:0] q_d8, q_t8;
    logic [0:0] q_t1;
    logic       to_d8, to_t8, to_t1;

    int checks = 0;
    int fails  = 0;

    logic [7:0] e_d8, e_t8, e_t1;

    always #2 clk = ~clk;

    dt_scan_reg #(.KIND(FF_D), .WIDTH(8), .HAS_AVAL(1'b1), .AVAL(8'hA5),
                  .HAS_SVAL(1'b1), .SVAL(8'h3C), .INIT_VAL(8'h5A)) dut (
        .clk(clk), .enable(enable), .data(data), .aclr(aclr), .aset(aset), .aload(zero),
        .sclr(sclr), .sset(sset), .sload(zero), .testenab(testenab), .testin(testin),
        .q(q_d8), .testout(to_d8));

    dt_scan_reg #(.KIND(FF_T), .WIDTH(8), .HAS_AVAL(1'b0), .AVAL(8'h00),
                  .HAS_SVAL(1'b0), .SVAL(8'h00), .INIT_VAL(8'h00)) dut_t8 (
        .clk(clk), .enable(enable), .data(data), .aclr(aclr), .aset(aset), .aload(aload),
        .sclr(sclr), .sset(sset), .sload(sload), .testenab(testenab), .testin(testin),
        .q(q_t8), .testout(to_t8));

    dt_scan_reg #(.KIND(FF_T), .WIDTH(1), .HAS_AVAL(1'b1), .AVAL(1'b0),
                  .HAS_SVAL(1'b1), .SVAL(1'b0), .INIT_VAL(1'b1)) dut_t1 (
        .clk(clk), .enable(enable), .data(data[0:0]), .aclr(aclr), .aset(aset), .aload(aload),
        .sclr(sclr), .sset(sset), .sload(sload), .testenab(testenab), .testin(testin),
        .q(q_t1), .testout(to_t1));

    // {enable, testenab, sclr, sset, sload, testin, data[7:0]}
    localparam logic [13:0] VEC [16] = '{
        {6'b100000, 8'h3C}, {6'b100000, 8'hF0}, {6'b100000, 8'h0F}, {6'b000000, 8'hFF},
        {6'b101000, 8'hAA}, {6'b100100, 8'h55}, {6'b100010, 8'h81}, {6'b100110, 8'h7E},
        {6'b101110, 8'h33}, {6'b110001, 8'h00}, {6'b110000, 8'hFF}, {6'b111111, 8'h12},
        {6'b010111, 8'hC3}, {6'b000100, 8'h99}, {6'b100000, 8'h99}, {6'b100001, 8'h01}
    };

    function automatic logic [7:0] model(input bit tmode, input int w, input logic [7:0] cur,
            input logic [7:0] din, input logic en, input logic te, input logic clr,
            input logic st, input logic ld, input logic tin, input logic [7:0] sval);
        logic [7:0] m;
        m = 8'((16'h1 << w) - 1);
        if (!en)              return cur;
        if (te)               return ((cur << 1) | {7'b0, tin}) & m;
        if (clr)              return 8'h00;
        if (st)               return sval & m;
        if (ld && tmode)      return din & m;
        if (tmode)            return (cur ^ din) & m;
        return din & m;
    endfunction

    function automatic string tag_of(input bit tmode, input logic en, input logic te,
            input logic clr, input logic st, input logic ld);
        if (!en) return "R3";
        if (te)  return "R11";
        if (clr) return "R4";
        if (st)  return "R5";
        if (ld && tmode) return "R6";
        return tmode ? "R2" : "R1";
    endfunction

    task automatic chk(input string tag, input string who, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, who, act, exp);
        end
    endtask

    task automatic check_all(input string tag_d, input string tag_t);
        chk(tag_d, "d8 q", q_d8, e_d8);
        chk(tag_t, "t8 q", q_t8, e_t8);
        chk(tag_t, "t1 q", {7'b0, q_t1}, e_t1);
        chk("R12", "d8 testout", {7'b0, to_d8}, {7'b0, e_d8[7]});
        chk("R12", "t8 testout", {7'b0, to_t8}, {7'b0, e_t8[7]});
        chk("R12", "t1 testout", {7'b0, to_t1}, {7'b0, e_t1[0]});
    endtask

    task automatic step(input logic [13:0] v);
        @(negedge clk);
        {enable, testenab, sclr, sset, sload, testin, data} = v;
        e_d8 = model(1'b0, 8, e_d8, data, enable, testenab, sclr, sset, 1'b0, testin, 8'h3C);
        e_t8 = model(1'b1, 8, e_t8, data, enable, testenab, sclr, sset, sload, testin, 8'hFF);
        e_t1 = model(1'b1, 1, e_t1, data, enable, testenab, sclr, sset, sload, testin, 8'h00);
        @(posedge clk);
        #1;
        check_all(tag_of(1'b0, enable, testenab, sclr, sset, 1'b0),
                  tag_of(1'b1, enable, testenab, sclr, sset, sload));
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R13: power-on value, before the first rising edge at 2 ns
        #1;
        e_d8 = 8'h5A; e_t8 = 8'h00; e_t1 = 8'h01;
        check_all("R13", "R13");

        // Table walk
        for (int i = 0; i < 16; i++) step(VEC[i]);

        // Random control mix, async low
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            step({r[0] | r[1], r[2] & r[3], r[4] & r[5], r[6] & r[7], r[8], r[9], r[23:16]});
        end

        // R7: immediate clear, no edge
        @(negedge clk);
        enable = 1'b0; sclr = 1'b0; sset = 1'b0; sload = 1'b0; testenab = 1'b0;
        aclr = 1'b1;
        #1;
        e_d8 = 8'h00; e_t8 = 8'h00; e_t1 = 8'h00;
        check_all("R7", "R7");
        // R7: clear beats set and load
        @(negedge clk);
        aset = 1'b1; aload = 1'b1; data = 8'hC6;
        #1;
        check_all("R7", "R7");
        // R10: release, hold across an edge with enable low
        @(negedge clk);
        aclr = 1'b0; aset = 1'b0; aload = 1'b0;
        @(posedge clk); #1;
        check_all("R10", "R10");

        // R8: immediate set, and set beats load
        @(negedge clk);
        aset = 1'b1;
        #1;
        e_d8 = 8'hA5; e_t8 = 8'hFF; e_t1 = 8'h00;
        check_all("R8", "R8");
        data = 8'h3B; aload = 1'b1;
        #1;
        check_all("R8", "R8");

        // R9: set released with load held; load captures at next clock edge
        @(negedge clk);
        aset = 1'b0;
        @(posedge clk); #1;
        e_t8 = 8'h3B; e_t1 = 8'h01;
        check_all("R10", "R9");
        @(negedge clk);
        data = 8'h64;
        @(posedge clk); #1;
        e_t8 = 8'h64; e_t1 = 8'h00;
        check_all("R10", "R9");

        // R9: fresh rising load captures at once
        @(negedge clk);
        aload = 1'b0;
        @(negedge clk);
        data = 8'hE7; aload = 1'b1;
        #1;
        e_t8 = 8'hE7; e_t1 = 8'h01;
        check_all("R10", "R9");

        // R10: after release, data changes do not reach q with enable low
        @(negedge clk);
        aload = 1'b0; data = 8'h18;
        @(posedge clk); #1;
        check_all("R10", "R10");
        @(posedge clk); #1;
        check_all("R10", "R10");

        // R11: fill the chain with ones, then drain with zeros
        for (int i = 0; i < 9; i++) step({6'b110001, 8'h00});
        for (int i = 0; i < 9; i++) step({6'b110000, 8'hFF});

        // R4/R5: clear beats set, set beats load
        step({6'b101110, 8'h44});
        step({6'b100110, 8'h44});
        step({6'b100010, 8'h44});

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule